// File: doc/BRIEF.md
# Multi-Lane Serial Transaction Sequencer

This block runs one serial transfer of a programmed number of bytes. Software sets the lane width, the transmit and receive directions and the byte count, then sets the run bit. After that, every strobe from an external bit-clock generator moves one group of bits. The block takes each outgoing byte from a first-word-fall-through transmit queue. It drives the byte onto one, two or four data lines, most significant bits first, and collects the sampled lines into bytes that it writes into a receive queue.

Either direction can be turned off. With transmit off, the block drives all-ones and reads nothing from the transmit queue. With receive off, it drops the sampled bits. When the transmit queue is empty, or the receive queue is full, the block holds its position without losing a bit. When the last byte has moved, it raises a one-cycle completion pulse and clears its own run bit. Writing the soft-reset bit abandons a transfer at any point.

Top module: `spi_xact_engine`

## Requirements
- R1: A control write with bit 0 set and bit 11 clear, made while idle, starts a transfer. The transfer uses the byte count in bits [31:16] of the size word, the lane field in control bits [7:5], receive-enable in bit 9 and transmit-enable in bit 10. busy_o is high from the next cycle.
- R2: With lane field 0, a byte takes 8 accepted strobes. Bit 7 goes out first on sd_o[0], and sd_i[0] is sampled on each strobe. sd_o[3:1] stay high.
- R3: With lane field 1, a byte takes 4 accepted strobes. sd_o[1] carries the higher bit of each pair and sd_o[0] the lower, and sd_i[1:0] are sampled with the same weighting. sd_o[3:2] stay high.
- R4: With lane field 2, a byte takes 2 accepted strobes. The high nibble goes first, with sd_o[3] carrying its top bit, and sd_i[3:0] are sampled with the same weighting.
- R5: Lane field values 3 to 7 behave as lane field 0.
- R6: With transmit disabled, the block never pops the transmit queue and drives all-ones on the active lanes.
- R7: With receive disabled, the block never pushes the receive queue.
- R8: A strobe at the first step of a byte is ignored while transmit is enabled and tx_empty_i is high.
- R9: A strobe at the final step of a byte is ignored while receive is enabled and rx_full_i is high. A pop already made for that byte is not repeated.
- R10: done_o pulses for exactly one cycle, in the cycle after the final strobe of the last byte. busy_o falls in that same cycle.
- R11: A start with a byte count of 0 gives done_o in the next cycle, and busy_o stays low.
- R12: A control write with bit 11 set abandons any transfer. busy_o is low and done_o is low from the next cycle, and no start is taken from that write.
- R13: A control write without bit 11, made while busy, changes neither the configuration nor the progress of the running transfer.
- R14: While idle, sd_o is all-ones, strobes are ignored and no queue is pushed or popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctl_wr_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 32 | Control word |
| size_word_i | input | 32 | Size word; byte count in [31:16] |
| shift_stb_i | input | 1 | One bit-group step from the clock generator |
| tx_empty_i | input | 1 | Transmit queue empty |
| tx_data_i | input | BYTE_W | Head of transmit queue |
| tx_pop_o | output | 1 | Take head of transmit queue |
| rx_full_i | input | 1 | Receive queue full |
| rx_push_o | output | 1 | Write rx_data_o into receive queue |
| rx_data_o | output | BYTE_W | Received byte |
| sd_i | input | LANES | Sampled data lines |
| sd_o | output | LANES | Driven data lines |
| busy_o | output | 1 | Run bit; clears itself at completion |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default values: a 16-bit count, 8-bit bytes and four lanes. With four lanes, every lane-field value can be used, including the reserved ones. The 16-bit count allows short transfers and the zero-count case. The byte width makes one byte cost 8, 4 or 2 strobes, so strobes at the first step and at the final step of a byte occur often. Transmit-empty and receive-full stalls can then be placed at those points, and an abort can fall partway through a byte.

// File: rtl/spi_xact_pkg.sv
package spi_xact_pkg;

  localparam int CTL_RUN_BIT  = 0;
  localparam int CTL_MODE_LSB = 5;
  localparam int CTL_RX_BIT   = 9;
  localparam int CTL_TX_BIT   = 10;
  localparam int CTL_SRST_BIT = 11;
  localparam int SIZE_LSB     = 16;

  typedef enum logic [1:0] {
    LANE_X1 = 2'd0,
    LANE_X2 = 2'd1,
    LANE_X4 = 2'd2
  } lane_cfg_e;

  typedef struct packed {
    lane_cfg_e lanes;
    logic      tx_en;
    logic      rx_en;
  } xact_cfg_t;

  // reserved encodings fall back to one lane
  function automatic lane_cfg_e decode_lanes(input logic [2:0] field);
    case (field)
      3'd1:    decode_lanes = LANE_X2;
      3'd2:    decode_lanes = LANE_X4;
      default: decode_lanes = LANE_X1;
    endcase
  endfunction

endpackage

// File: rtl/spi_ctl_decode.sv
module spi_ctl_decode
  import spi_xact_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_wr_i,
  input  logic [31:0]      ctl_wdata_i,
  input  logic [31:0]      size_word_i,
  input  logic             busy_i,
  output logic             start_o,
  output logic             abort_o,
  output logic [CNT_W-1:0] count_o,
  output xact_cfg_t        cfg_o
);

  xact_cfg_t cfg_q;

  assign abort_o = ctl_wr_i && ctl_wdata_i[CTL_SRST_BIT];
  assign start_o = ctl_wr_i && ctl_wdata_i[CTL_RUN_BIT] &&
                   !ctl_wdata_i[CTL_SRST_BIT] && !busy_i;
  assign count_o = size_word_i[SIZE_LSB +: CNT_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '{lanes: LANE_X1, tx_en: 1'b0, rx_en: 1'b0};
    end else if (start_o) begin
      cfg_q.lanes <= decode_lanes(ctl_wdata_i[CTL_MODE_LSB +: 3]);
      cfg_q.tx_en <= ctl_wdata_i[CTL_TX_BIT];
      cfg_q.rx_en <= ctl_wdata_i[CTL_RX_BIT];
    end
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/spi_byte_counter.sv
module spi_byte_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             byte_done_i,
  output logic             busy_o,
  output logic             done_o
);

  logic [CNT_W-1:0] rem_q;
  logic             busy_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (abort_i) begin
      rem_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      rem_q  <= count_i;
      busy_q <= (count_i != '0);
      done_q <= (count_i == '0);
    end else begin
      done_q <= 1'b0;
      if (busy_q && byte_done_i) begin
        rem_q <= rem_q - 1'b1;
        if (rem_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

endmodule

// File: rtl/spi_lane_shifter.sv
module spi_lane_shifter
  import spi_xact_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  xact_cfg_t         cfg_i,
  input  logic              busy_i,
  input  logic              restart_i,
  input  logic              stb_i,
  input  logic              tx_empty_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  input  logic              rx_full_i,
  input  logic [LANES-1:0]  sd_i,
  output logic [LANES-1:0]  sd_o,
  output logic              tx_pop_o,
  output logic              rx_push_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              byte_done_o
);

  localparam int BEAT_W = $clog2(BYTE_W);
  localparam int SH_W   = BEAT_W + 1;

  logic [BEAT_W-1:0] beat_q, beat_last;
  logic [BYTE_W-1:0] tx_sh_q, rx_sh_q;
  logic [BYTE_W-1:0] cur_byte, top_bits, rx_next, in_wide;
  logic [LANES-1:0]  in_bits;
  logic [SH_W-1:0]   lane_n, shamt;
  logic              first_step, last_step, stall_tx, stall_rx, go;

  always_comb begin
    case (cfg_i.lanes)
      LANE_X2: lane_n = SH_W'(2);
      LANE_X4: lane_n = SH_W'(4);
      default: lane_n = SH_W'(1);
    endcase
  end

  assign beat_last  = BEAT_W'((BYTE_W / int'(lane_n)) - 1);
  assign first_step = (beat_q == '0);
  assign last_step  = (beat_q == beat_last);

  assign cur_byte = first_step ? (cfg_i.tx_en ? tx_data_i : '1) : tx_sh_q;
  assign shamt    = SH_W'(BYTE_W) - lane_n;
  assign top_bits = cur_byte >> shamt;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb begin
      if (busy_i && (SH_W'(l) < lane_n)) begin
        sd_o[l]    = top_bits[l];
        in_bits[l] = sd_i[l];
      end else begin
        sd_o[l]    = 1'b1;
        in_bits[l] = 1'b0;
      end
    end
  end

  assign in_wide = BYTE_W'(in_bits);
  assign rx_next = (rx_sh_q << lane_n) | in_wide;

  assign stall_tx = first_step && cfg_i.tx_en && tx_empty_i;
  assign stall_rx = last_step && cfg_i.rx_en && rx_full_i;
  assign go       = busy_i && stb_i && !stall_tx && !stall_rx;

  assign tx_pop_o    = go && first_step && cfg_i.tx_en;
  assign rx_push_o   = go && last_step && cfg_i.rx_en;
  assign rx_data_o   = rx_next;
  assign byte_done_o = go && last_step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_q  <= '0;
      tx_sh_q <= '1;
      rx_sh_q <= '0;
    end else if (restart_i) begin
      beat_q  <= '0;
      tx_sh_q <= '1;
      rx_sh_q <= '0;
    end else if (go) begin
      tx_sh_q <= cur_byte << lane_n;
      rx_sh_q <= last_step ? '0 : rx_next;
      beat_q  <= last_step ? '0 : beat_q + 1'b1;
    end
  end

endmodule

// File: rtl/spi_xact_engine.sv
module spi_xact_engine
  import spi_xact_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_wr_i,
  input  logic [31:0]       ctl_wdata_i,
  input  logic [31:0]       size_word_i,
  input  logic              shift_stb_i,
  input  logic              tx_empty_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  output logic              tx_pop_o,
  input  logic              rx_full_i,
  output logic              rx_push_o,
  output logic [BYTE_W-1:0] rx_data_o,
  input  logic [LANES-1:0]  sd_i,
  output logic [LANES-1:0]  sd_o,
  output logic              busy_o,
  output logic              done_o
);

  logic             start, abort, byte_done, busy;
  logic [CNT_W-1:0] count;
  xact_cfg_t        cfg;

  spi_ctl_decode #(.CNT_W(CNT_W)) i_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctl_wr_i   (ctl_wr_i),
    .ctl_wdata_i(ctl_wdata_i),
    .size_word_i(size_word_i),
    .busy_i     (busy),
    .start_o    (start),
    .abort_o    (abort),
    .count_o    (count),
    .cfg_o      (cfg)
  );

  spi_byte_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .abort_i    (abort),
    .count_i    (count),
    .byte_done_i(byte_done),
    .busy_o     (busy),
    .done_o     (done_o)
  );

  spi_lane_shifter #(.BYTE_W(BYTE_W), .LANES(LANES)) i_shf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_i      (cfg),
    .busy_i     (busy),
    .restart_i  (start || abort),
    .stb_i      (shift_stb_i),
    .tx_empty_i (tx_empty_i),
    .tx_data_i  (tx_data_i),
    .rx_full_i  (rx_full_i),
    .sd_i       (sd_i),
    .sd_o       (sd_o),
    .tx_pop_o   (tx_pop_o),
    .rx_push_o  (rx_push_o),
    .rx_data_o  (rx_data_o),
    .byte_done_o(byte_done)
  );

  assign busy_o = busy;

endmodule

// File: rtl/spi_xact_checker.sv
module spi_xact_checker #(
  parameter int CNT_W = 16,
  parameter int LANES = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ctl_wr_i,
  input logic [31:0]      ctl_wdata_i,
  input logic [31:0]      size_word_i,
  input logic             shift_stb_i,
  input logic             tx_empty_i,
  input logic             tx_pop_o,
  input logic             rx_full_i,
  input logic             rx_push_o,
  input logic [LANES-1:0] sd_o,
  input logic             busy_o,
  input logic             done_o
);

  a_r8_no_pop_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop_o |-> !tx_empty_i);

  a_r9_no_push_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_o |-> !rx_full_i);

  a_r14_moves_need_busy_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_pop_o || rx_push_o) |-> (busy_o && shift_stb_i));

  a_r14_idle_lines_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (sd_o == '1));

  a_r10_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r10_done_while_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r12_abort_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr_i && ctl_wdata_i[11]) |=> (!busy_o && !done_o));

  a_r1_start_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr_i && ctl_wdata_i[0] && !ctl_wdata_i[11] && !busy_o &&
     (size_word_i[16 +: CNT_W] != '0)) |=> busy_o);

  a_r11_zero_count_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr_i && ctl_wdata_i[0] && !ctl_wdata_i[11] && !busy_o &&
     (size_word_i[16 +: CNT_W] == '0)) |=> (done_o && !busy_o));

endmodule

bind spi_xact_engine spi_xact_checker #(.CNT_W(CNT_W), .LANES(LANES)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ctl_wr_i   (ctl_wr_i),
  .ctl_wdata_i(ctl_wdata_i),
  .size_word_i(size_word_i),
  .shift_stb_i(shift_stb_i),
  .tx_empty_i (tx_empty_i),
  .tx_pop_o   (tx_pop_o),
  .rx_full_i  (rx_full_i),
  .rx_push_o  (rx_push_o),
  .sd_o       (sd_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/test_spi_xact_engine.sv
module test_spi_xact_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic [31:0] size_w = '0;
  logic        stb = 1'b0;
  logic        tx_empty_r = 1'b1;
  logic [7:0]  tx_data_r = '0;
  logic        rx_full = 1'b0;
  logic [3:0]  sdi = 4'h9;
  logic        tx_pop, rx_push, busy, done;
  logic [7:0]  rx_data;
  logic [3:0]  sdo;

  always #4 clk = ~clk;

  spi_xact_engine i_spi_xact_engine (
    .clk_i(clk), .rst_ni(rst_n), .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wdata),
    .size_word_i(size_w), .shift_stb_i(stb), .tx_empty_i(tx_empty_r),
    .tx_data_i(tx_data_r), .tx_pop_o(tx_pop), .rx_full_i(rx_full),
    .rx_push_o(rx_push), .rx_data_o(rx_data), .sd_i(sdi), .sd_o(sdo),
    .busy_o(busy), .done_o(done)
  );

  int checks = 0, fails = 0, cycles = 0, done_seen = 0;
  string cur_req = "R14";
  byte unsigned txq[$];
  byte unsigned rxq[$];

  // reference model state
  bit m_busy = 0, m_done = 0, m_tx = 0, m_rx = 0;
  int m_rem = 0, m_beat = 0, m_n = 1, m_cur = 0, m_acc = 0;
  bit n_busy, n_done, n_tx, n_rx, act_pop, act_push;
  int n_rem, n_beat, n_n, n_cur, n_acc, push_val;
  bit model_on = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void refresh();
    tx_empty_r = (txq.size() == 0);
    tx_data_r  = (txq.size() == 0) ? 8'h00 : txq[0];
  endfunction

  function automatic int lanes_of(input int field);
    if (field == 1) return 2;
    if (field == 2) return 4;
    return 1;
  endfunction

  always @(negedge clk) sdi <= {sdi[2:0], sdi[3] ^ sdi[2]};

  // compare every cycle, compute next model state
  always @(negedge clk) begin
    #1;
    act_pop = 0; act_push = 0;
    if (model_on) begin
      int beats, mask, bytev, bits, exp_sd, accn;
      bit lst, go, e_pop, e_push;
      beats = 8 / m_n;
      mask  = (1 << m_n) - 1;
      lst   = (m_beat == beats - 1);
      bytev = (m_beat == 0) ? (m_tx ? int'(tx_data_r) : 8'hFF) : m_cur;
      bits  = (bytev >> (8 - m_n * (m_beat + 1))) & mask;
      exp_sd = m_busy ? ((15 & ~mask) | bits) : 15;
      accn  = ((m_acc << m_n) | (int'(sdi) & mask)) & 8'hFF;
      go    = m_busy && stb && !(m_beat == 0 && m_tx && tx_empty_r) &&
              !(lst && m_rx && rx_full);
      e_pop  = go && m_beat == 0 && m_tx;
      e_push = go && lst && m_rx;
      chk(sdo == exp_sd[3:0], cur_req, "sd_o", sdo, exp_sd);
      chk(tx_pop == e_pop, cur_req, "tx_pop_o", tx_pop, e_pop);
      chk(rx_push == e_push, cur_req, "rx_push_o", rx_push, e_push);
      chk(busy == m_busy, "R1", "busy_o", busy, m_busy);
      chk(done == m_done, "R10", "done_o", done, m_done);
      if (e_push) chk(rx_data == accn[7:0], cur_req, "rx_data_o", rx_data, accn);
      if (done) done_seen++;
      n_busy = m_busy; n_done = 0; n_tx = m_tx; n_rx = m_rx; n_rem = m_rem;
      n_beat = m_beat; n_n = m_n; n_cur = m_cur; n_acc = m_acc;
      if (ctl_wr && ctl_wdata[11]) begin
        n_busy = 0;
      end else if (ctl_wr && ctl_wdata[0] && !m_busy) begin
        n_n = lanes_of(int'(ctl_wdata[7:5]));
        n_tx = ctl_wdata[10]; n_rx = ctl_wdata[9];
        n_rem = int'(size_w[31:16]); n_beat = 0; n_acc = 0;
        if (n_rem == 0) n_done = 1; else n_busy = 1;
      end else if (go) begin
        if (m_beat == 0) n_cur = bytev;
        act_pop = e_pop; act_push = e_push; push_val = accn;
        n_acc = accn;
        if (lst) begin
          n_beat = 0; n_acc = 0; n_rem = m_rem - 1;
          if (n_rem == 0) begin n_busy = 0; n_done = 1; end
        end else n_beat = m_beat + 1;
      end
    end
  end

  always @(posedge clk) begin
    #1;
    cycles++;
    if (model_on) begin
      m_busy = n_busy; m_done = n_done; m_tx = n_tx; m_rx = n_rx; m_rem = n_rem;
      m_beat = n_beat; m_n = n_n; m_cur = n_cur; m_acc = n_acc;
      if (act_pop && txq.size() > 0) void'(txq.pop_front());
      if (act_push) rxq.push_back(8'(push_val));
      refresh();
    end
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [31:0] ctl(input int mode, input bit tx, input bit rx,
                                      input bit run, input bit srst);
    return (32'(run)) | (32'(mode & 7) << 5) | (32'(rx) << 9) |
           (32'(tx) << 10) | (32'(srst) << 11);
  endfunction

  task automatic cyc(input bit s);
    @(negedge clk);
    ctl_wr = 0; stb = s;
  endtask

  task automatic write_ctl(input logic [31:0] w, input int count);
    @(negedge clk);
    ctl_wr = 1; ctl_wdata = w; size_w = 32'(count) << 16; stb = 0;
  endtask

  task automatic run(input int period);
    for (int k = 0; k < 4000; k++) begin
      cyc(period <= 1 || (k % period) == 0);
      if (!m_busy) break;
    end
    cyc(0); cyc(0);
  endtask

  task automatic load(input byte unsigned b);
    txq.push_back(b);
    refresh();
  endtask

  task automatic xact(input string req, input int mode, input int nbytes, input int period);
    int d0, r0;
    cur_req = req;
    d0 = done_seen; r0 = rxq.size();
    for (int i = 0; i < nbytes; i++) load(8'(8'h5A + 37 * i + mode));
    write_ctl(ctl(mode, 1, 1, 1, 0), nbytes);
    cyc(0);
    chk(busy == 1, "R1", "busy after start", busy, 1);
    run(period);
    chk(done_seen - d0 == 1, "R10", "done pulses", done_seen - d0, 1);
    chk(rxq.size() - r0 == nbytes, req, "rx bytes", rxq.size() - r0, nbytes);
    chk(txq.size() == 0, req, "tx drained", txq.size(), 0);
  endtask

  initial begin
    int d0, r0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(busy == 0, "R14", "reset busy", busy, 0);
    chk(done == 0, "R14", "reset done", done, 0);
    chk(sdo == 4'hF, "R14", "reset lines", sdo, 15);
    model_on = 1;
    cyc(1); cyc(1); cyc(0);
    chk(tx_pop == 0 && rx_push == 0, "R14", "idle strobe", tx_pop, 0);

    xact("R2", 0, 3, 2);
    xact("R3", 1, 4, 1);
    xact("R4", 2, 5, 1);
    xact("R5", 5, 2, 1);
    xact("R5", 3, 1, 3);

    // transmit off
    cur_req = "R6";
    load(8'hC3);
    r0 = rxq.size();
    write_ctl(ctl(0, 0, 1, 1, 0), 2);
    run(1);
    chk(txq.size() == 1, "R6", "tx untouched", txq.size(), 1);
    chk(rxq.size() - r0 == 2, "R6", "rx bytes", rxq.size() - r0, 2);
    txq.delete(); refresh();

    // receive off
    cur_req = "R7";
    r0 = rxq.size();
    load(8'h11); load(8'hEE);
    write_ctl(ctl(1, 1, 0, 1, 0), 2);
    run(1);
    chk(rxq.size() == r0, "R7", "no rx", rxq.size(), r0);
    chk(txq.size() == 0, "R7", "tx drained", txq.size(), 0);

    // transmit empty stall
    cur_req = "R8";
    r0 = rxq.size();
    write_ctl(ctl(2, 1, 1, 1, 0), 2);
    repeat (6) cyc(1);
    chk(busy == 1, "R8", "still busy", busy, 1);
    chk(rxq.size() == r0, "R8", "no progress", rxq.size(), r0);
    load(8'hB7); load(8'h48);
    run(1);
    chk(rxq.size() - r0 == 2, "R8", "rx after stall", rxq.size() - r0, 2);

    // receive full stall
    cur_req = "R9";
    r0 = rxq.size();
    load(8'h9C); load(8'h63);
    rx_full = 1;
    write_ctl(ctl(2, 1, 1, 1, 0), 2);
    repeat (6) cyc(1);
    chk(busy == 1, "R9", "still busy", busy, 1);
    chk(txq.size() == 1, "R9", "one pop only", txq.size(), 1);
    chk(rxq.size() == r0, "R9", "no push", rxq.size(), r0);
    rx_full = 0;
    run(1);
    chk(rxq.size() - r0 == 2, "R9", "rx after stall", rxq.size() - r0, 2);

    // zero count
    cur_req = "R11";
    d0 = done_seen;
    write_ctl(ctl(0, 1, 1, 1, 0), 0);
    cyc(0);
    chk(done == 1, "R11", "done next", done, 1);
    chk(busy == 0, "R11", "busy low", busy, 0);
    cyc(0);
    chk(done_seen - d0 == 1, "R11", "one pulse", done_seen - d0, 1);

    // write during busy ignored
    cur_req = "R13";
    r0 = rxq.size();
    for (int i = 0; i < 3; i++) load(8'(8'h21 * (i + 1)));
    write_ctl(ctl(2, 1, 1, 1, 0), 3);
    cyc(1); cyc(1);
    write_ctl(ctl(0, 0, 0, 1, 0), 9);
    run(1);
    chk(rxq.size() - r0 == 3, "R13", "rx bytes", rxq.size() - r0, 3);

    // soft reset
    cur_req = "R12";
    d0 = done_seen;
    for (int i = 0; i < 4; i++) load(8'(8'hF0 - i));
    write_ctl(ctl(0, 1, 1, 1, 0), 4);
    repeat (5) cyc(1);
    write_ctl(ctl(0, 1, 1, 0, 1), 0);
    cyc(1);
    chk(busy == 0, "R12", "busy after abort", busy, 0);
    write_ctl(ctl(0, 1, 1, 1, 1), 4);
    cyc(1); cyc(1);
    chk(busy == 0, "R12", "reset wins", busy, 0);
    write_ctl(32'h0, 0);
    repeat (4) cyc(1);
    chk(done_seen == d0, "R12", "no done", done_seen - d0, 0);
    txq.delete(); refresh();
    xact("R12", 2, 1, 1);

    cyc(0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule